// File: doc/BRIEF.md
# External Memory Bus Sequencer

The sequencer turns single transfers from an internal request port into strobe sequences on an external asynchronous parallel memory bus. The bus has six active-low chip-select lines, a 9-bit address field, a 16-bit data path with separate output, input and output-enable signals, and active-low strobes for output enable (OE), write enable (WE) and address valid (ADV). Each chip select carries its own timing set. Software loads this set through a small field-write port. The timing set covers first-access latency, wait states, read lead, ADV-to-OE spacing, address hold, write hold and bus-turnaround recovery.

A request is offered with `req_valid`. It is accepted on a clock edge where `req_ready` is high, and the sequencer is then busy until the access has fully ended. The controller is one state machine with these states:

- **ST_IDLE**: ready, and no chip select is asserted. An accepted request moves to ST_RECOV if turnaround is needed, and to ST_ADV otherwise.
- **ST_RECOV**: all chip selects are high for the recovery count, then the machine moves to ST_ADV.
- **ST_ADV**: one cycle with the chip select and ADV low. The next state is ST_AHOLD when address hold is enabled. Otherwise the machine enters the delta/main phase.
- **ST_AHOLD**: one extra cycle that keeps the address stable, then the delta/main phase.
- **ST_DELTA**: the first-access latency. It is entered only when the access is a first access and its delta is non-zero, then the main phase.
- **ST_LEAD**: the read lead before OE, then ST_STROBE.
- **ST_STROBE**: OE is low for a read and WE is low for a write. A read then returns to ST_IDLE and a write moves to ST_WHOLD.
- **ST_WHOLD**: the write hold, then ST_IDLE.

Top module: `xbus_ctrl`

## Requirements
- R1: Reset state:
  - `mem_cs_n` is all ones.
  - `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high.
  - `mem_be_n` is 2'b11.
  - `mem_doe` is 0, `rd_done` is 0 and `req_ready` is 1.
  - All timing fields of all chip selects read as zero.
- R2: A pulse on `cfg_we` writes the low bits of `cfg_wdata` into one field of chip select `cfg_cs`. The field codes are:
  - 0: recovery (4 bits)
  - 1: write hold (4 bits)
  - 2: write delta (8 bits)
  - 3: read delta (8 bits)
  - 4: write wait (4 bits)
  - 5: read wait (4 bits)
  - 6: address-hold enable (bit 0)
  - 7: ADV-to-OE spacing (bits 1:0)
  - 8: read hold (4 bits)

  A write with a field code of 9 or above, or with `cfg_cs` of 6 or above, changes no timing.
- R3: During an access, only the line `mem_cs_n[req_cs]` is low. `mem_addr` equals the request address on every CS-low cycle. ADV is low for exactly one cycle, which is the first CS-low cycle.
- R4: When address hold is enabled, exactly one CS-low cycle is added right after the ADV cycle, before any latency.
- R5: For a read, the first OE-low cycle comes 1+A+D+max(H,S) cycles after the ADV cycle, where:
  - A is the address-hold bit.
  - D is the applied delta (see R7).
  - H is the read hold.
  - S is the ADV-to-OE spacing.

  OE stays low for 1+read-wait cycles. CS rises in the same cycle that OE rises.
- R6: For a write, WE goes low 1+A+D cycles after the ADV cycle and stays low for 1+write-wait cycles. CS then stays low for a further write-hold+1 cycles. `mem_doe` is high and `mem_dout` holds the write data from the first WE cycle through the last hold cycle.
- R7: D equals the read or write delta of the chip select when the access is a first access. It is 0 when the access uses the same chip select and the same address bits 8:4 as the previously accepted access.
- R8: Recovery cycles are inserted only when the previous access was a read and either the chip select differs or the new access is a write. The recovery length is max(R,1), where R is the recovery field of the previous read's chip select as it stood when that read completed. During recovery all chip selects are high. When no recovery is needed, ADV is low in the first cycle after acceptance.
- R9: For a read, `rd_data` holds `mem_din` as sampled in the last OE-low cycle. `rd_done` is high for exactly one cycle, the cycle in which OE rises. Writes never raise `rd_done`.
- R10: `req_ready` is low from the cycle after acceptance through the last CS-low cycle. It is high again in the next cycle, and is high whenever no chip select is asserted by the sequencer.
- R11: `mem_be_n` is 2'b00 on word accesses. On byte accesses (`req_byte`=1) it is 2'b10 when address bit 0 is 0 and 2'b01 when it is 1. It is 2'b11 outside accesses.
- R12: `mem_doe` is never high while `mem_oe_n` is low, and OE and WE are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing field write strobe |
| cfg_cs | input | 3 | Chip select whose timing is written |
| cfg_field | input | 4 | Field code (R2) |
| cfg_wdata | input | 8 | Field value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_cs | input | 3 | Target chip select, 0 to 5 |
| req_addr | input | 9 | Word address on the external bus |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_byte | input | 1 | Single-byte access |
| rd_done | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Returned read data |
| mem_cs_n | output | 6 | Active-low chip selects |
| mem_addr | output | 9 | External address |
| mem_adv_n | output | 1 | Active-low address valid |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low byte lane enables |
| mem_dout | output | 16 | Data driven towards the bus |
| mem_doe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Data read from the bus |

## Verification
Every state and its countdown show directly as strobe timing. A wrong count or a wrong branch therefore appears in the same access as a CS, OE or WE window that is one or more cycles too long or too short, or as an ADV or OE start that is displaced. Stale page or last-read tracking does not affect the access it was recorded on. It shows one access later, as a wrongly charged or skipped delta, or as recovery cycles before ADV that are missing or extra. A bad capture register shows in the `rd_data` that comes with that read's `rd_done` pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // Field widths of one chip-select timing set
    localparam int REC_W   = 4;
    localparam int HOLD_W  = 4;
    localparam int WAIT_W  = 4;
    localparam int DELTA_W = 8;
    localparam int A2O_W   = 2;
    localparam int CNT_W   = DELTA_W;

    typedef struct packed {
        logic [REC_W-1:0]   rec;
        logic [HOLD_W-1:0]  whold;
        logic [DELTA_W-1:0] wdelta;
        logic [DELTA_W-1:0] rdelta;
        logic [WAIT_W-1:0]  wwait;
        logic [WAIT_W-1:0]  rwait;
        logic               ahold;
        logic [A2O_W-1:0]   a2o;
        logic [HOLD_W-1:0]  rhold;
    } cs_timing_t;

    // Field codes of the configuration port
    localparam logic [3:0] FLD_REC    = 4'd0;
    localparam logic [3:0] FLD_WHOLD  = 4'd1;
    localparam logic [3:0] FLD_WDELTA = 4'd2;
    localparam logic [3:0] FLD_RDELTA = 4'd3;
    localparam logic [3:0] FLD_WWAIT  = 4'd4;
    localparam logic [3:0] FLD_RWAIT  = 4'd5;
    localparam logic [3:0] FLD_AHOLD  = 4'd6;
    localparam logic [3:0] FLD_A2O    = 4'd7;
    localparam logic [3:0] FLD_RHOLD  = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECOV,
        ST_ADV,
        ST_AHOLD,
        ST_DELTA,
        ST_LEAD,
        ST_STROBE,
        ST_WHOLD
    } bus_state_e;

endpackage

// File: rtl/xbus_cfg_bank.sv
module xbus_cfg_bank
    import xbus_pkg::*;
#(
    parameter int NCS = 6,
    parameter int CSW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CSW-1:0]   cfg_cs,
    input  logic [3:0]       cfg_field,
    input  logic [7:0]       cfg_wdata,
    input  logic [CSW-1:0]   rd_cs,
    output cs_timing_t       rd_tim
);

    cs_timing_t bank [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_slot
        cs_timing_t slot;
        logic       hit;

        assign hit = cfg_we && (cfg_cs == CSW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot <= '0;
            end else if (hit) begin
                case (cfg_field)
                    FLD_REC:    slot.rec    <= cfg_wdata[REC_W-1:0];
                    FLD_WHOLD:  slot.whold  <= cfg_wdata[HOLD_W-1:0];
                    FLD_WDELTA: slot.wdelta <= cfg_wdata[DELTA_W-1:0];
                    FLD_RDELTA: slot.rdelta <= cfg_wdata[DELTA_W-1:0];
                    FLD_WWAIT:  slot.wwait  <= cfg_wdata[WAIT_W-1:0];
                    FLD_RWAIT:  slot.rwait  <= cfg_wdata[WAIT_W-1:0];
                    FLD_AHOLD:  slot.ahold  <= cfg_wdata[0];
                    FLD_A2O:    slot.a2o    <= cfg_wdata[A2O_W-1:0];
                    FLD_RHOLD:  slot.rhold  <= cfg_wdata[HOLD_W-1:0];
                    default:    ;
                endcase
            end
        end

        assign bank[g] = slot;
    end

    assign rd_tim = (int'(rd_cs) < NCS) ? bank[rd_cs] : '0;

endmodule

// File: rtl/xbus_page_track.sv
module xbus_page_track #(
    parameter int CSW      = 3,
    parameter int AW       = 9,
    parameter int PAGE_LSB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc,
    input  logic [CSW-1:0] acc_cs,
    input  logic [AW-1:0]  acc_addr,
    input  logic           acc_write,
    output logic           first_acc,
    output logic           need_rec
);

    localparam int PW = AW - PAGE_LSB;

    logic           have_q;
    logic           was_read_q;
    logic [CSW-1:0] cs_q;
    logic [PW-1:0]  page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q     <= 1'b0;
            was_read_q <= 1'b0;
            cs_q       <= '0;
            page_q     <= '0;
        end else if (acc) begin
            have_q     <= 1'b1;
            was_read_q <= !acc_write;
            cs_q       <= acc_cs;
            page_q     <= acc_addr[AW-1:PAGE_LSB];
        end
    end

    always_comb begin
        first_acc = !(have_q && (cs_q == acc_cs) &&
                      (page_q == acc_addr[AW-1:PAGE_LSB]));
        need_rec  = have_q && was_read_q && ((cs_q != acc_cs) || acc_write);
    end

endmodule

// File: rtl/xbus_seq_fsm.sv
module xbus_seq_fsm
    import xbus_pkg::*;
#(
    parameter int NCS = 6,
    parameter int CSW = 3,
    parameter int AW  = 9,
    parameter int DW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    output logic            accept,
    input  logic [CSW-1:0]  req_cs,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            req_write,
    input  logic            req_byte,
    input  logic            first_acc,
    input  logic            need_rec,
    output logic [CSW-1:0]  cur_cs,
    input  cs_timing_t      tim,
    output logic            rd_done,
    output logic [DW-1:0]   rd_data,
    output logic [NCS-1:0]  mem_cs_n,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_adv_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic [DW/8-1:0] mem_be_n,
    output logic [DW-1:0]   mem_dout,
    output logic            mem_doe,
    input  logic [DW-1:0]   mem_din
);

    localparam int NBL = DW / 8;
    localparam int LW  = (NBL > 1) ? $clog2(NBL) : 1;

    bus_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      wdata_q;
    logic               wr_q;
    logic               byte_q;
    logic               first_q;
    logic [REC_W-1:0]   last_rec_q;
    logic               rd_end;

    // Derived phase lengths and the entry points of later phases
    logic [DELTA_W-1:0] dval;
    logic [HOLD_W-1:0]  lead;
    logic [REC_W-1:0]   rec_len;
    bus_state_e         main_st, dl_st;
    logic [CNT_W-1:0]   main_cnt, dl_cnt;
    logic               cnt_zero;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cnt_zero  = (cnt_q == '0);
    assign rd_end    = (state_q == ST_STROBE) && !wr_q && cnt_zero;

    always_comb begin
        dval    = wr_q ? tim.wdelta : tim.rdelta;
        lead    = (tim.rhold > {{(HOLD_W-A2O_W){1'b0}}, tim.a2o})
                  ? tim.rhold : {{(HOLD_W-A2O_W){1'b0}}, tim.a2o};
        rec_len = (last_rec_q == '0) ? REC_W'(1) : last_rec_q;

        if (!wr_q && (lead != '0)) begin
            main_st  = ST_LEAD;
            main_cnt = CNT_W'(lead - HOLD_W'(1));
        end else begin
            main_st  = ST_STROBE;
            main_cnt = CNT_W'(wr_q ? tim.wwait : tim.rwait);
        end

        if (first_q && (dval != '0)) begin
            dl_st  = ST_DELTA;
            dl_cnt = CNT_W'(dval - DELTA_W'(1));
        end else begin
            dl_st  = main_st;
            dl_cnt = main_cnt;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (need_rec) begin
                        state_d = ST_RECOV;
                        cnt_d   = CNT_W'(rec_len - REC_W'(1));
                    end else begin
                        state_d = ST_ADV;
                        cnt_d   = '0;
                    end
                end
            end
            ST_RECOV: begin
                if (cnt_zero) begin
                    state_d = ST_ADV;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_ADV: begin
                if (tim.ahold) begin
                    state_d = ST_AHOLD;
                    cnt_d   = '0;
                end else begin
                    state_d = dl_st;
                    cnt_d   = dl_cnt;
                end
            end
            ST_AHOLD: begin
                state_d = dl_st;
                cnt_d   = dl_cnt;
            end
            ST_DELTA: begin
                if (cnt_zero) begin
                    state_d = main_st;
                    cnt_d   = main_cnt;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_LEAD: begin
                if (cnt_zero) begin
                    state_d = ST_STROBE;
                    cnt_d   = CNT_W'(tim.rwait);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    if (wr_q) begin
                        state_d = ST_WHOLD;
                        cnt_d   = CNT_W'(tim.whold);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_WHOLD: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Request capture, recovery memory and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cs     <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            wr_q       <= 1'b0;
            byte_q     <= 1'b0;
            first_q    <= 1'b0;
            last_rec_q <= '0;
            rd_done    <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_done <= rd_end;
            if (accept) begin
                cur_cs  <= req_cs;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wr_q    <= req_write;
                byte_q  <= req_byte;
                first_q <= first_acc;
            end
            if (rd_end) begin
                rd_data    <= mem_din;
                last_rec_q <= tim.rec;
            end
        end
    end

    // Bus outputs decoded from the state
    always_comb begin
        logic active;
        active    = !(state_q inside {ST_IDLE, ST_RECOV});
        mem_cs_n  = '1;
        mem_be_n  = '1;
        if (active) begin
            mem_cs_n = ~(NCS'(1) << cur_cs);
            mem_be_n = byte_q ? ~(NBL'(1) << addr_q[LW-1:0]) : '0;
        end
        mem_addr  = addr_q;
        mem_dout  = wdata_q;
        mem_adv_n = (state_q != ST_ADV);
        mem_oe_n  = !((state_q == ST_STROBE) && !wr_q);
        mem_we_n  = !((state_q == ST_STROBE) && wr_q);
        mem_doe   = wr_q && ((state_q == ST_STROBE) || (state_q == ST_WHOLD));
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int NCS      = 6,
    parameter int AW       = 9,
    parameter int DW       = 16,
    parameter int PAGE_LSB = 4,
    localparam int CSW     = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CSW-1:0]  cfg_cs,
    input  logic [3:0]      cfg_field,
    input  logic [7:0]      cfg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [CSW-1:0]  req_cs,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            req_write,
    input  logic            req_byte,
    output logic            rd_done,
    output logic [DW-1:0]   rd_data,
    output logic [NCS-1:0]  mem_cs_n,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_adv_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic [DW/8-1:0] mem_be_n,
    output logic [DW-1:0]   mem_dout,
    output logic            mem_doe,
    input  logic [DW-1:0]   mem_din
);

    cs_timing_t     tim;
    logic [CSW-1:0] cur_cs;
    logic           accept;
    logic           first_acc;
    logic           need_rec;

    xbus_cfg_bank #(.NCS(NCS), .CSW(CSW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_cs    (cfg_cs),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .rd_cs     (cur_cs),
        .rd_tim    (tim)
    );

    xbus_page_track #(.CSW(CSW), .AW(AW), .PAGE_LSB(PAGE_LSB)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (accept),
        .acc_cs    (req_cs),
        .acc_addr  (req_addr),
        .acc_write (req_write),
        .first_acc (first_acc),
        .need_rec  (need_rec)
    );

    xbus_seq_fsm #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_byte  (req_byte),
        .first_acc (first_acc),
        .need_rec  (need_rec),
        .cur_cs    (cur_cs),
        .tim       (tim),
        .rd_done   (rd_done),
        .rd_data   (rd_data),
        .mem_cs_n  (mem_cs_n),
        .mem_addr  (mem_addr),
        .mem_adv_n (mem_adv_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_be_n  (mem_be_n),
        .mem_dout  (mem_dout),
        .mem_doe   (mem_doe),
        .mem_din   (mem_din)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int NCS = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           rd_done,
    input logic [NCS-1:0] mem_cs_n,
    input logic           mem_adv_n,
    input logic           mem_oe_n,
    input logic           mem_we_n,
    input logic           mem_doe
);

    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    p_adv_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (mem_cs_n != '1));

    p_adv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |=> mem_adv_n);

    p_oe_we_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_no_drive_on_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> mem_oe_n);

    p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_cs_n == '1));

    p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ((mem_cs_n != '1) && mem_doe));

    p_done_with_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> rd_done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n == '1));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_done   (rd_done),
    .mem_cs_n  (mem_cs_n),
    .mem_adv_n (mem_adv_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_doe   (mem_doe)
);

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_cs;
    logic [3:0]  cfg_field;
    logic [7:0]  cfg_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_cs;
    logic [8:0]  req_addr;
    logic [15:0] req_wdata;
    logic        req_write;
    logic        req_byte;
    logic        rd_done;
    logic [15:0] rd_data;
    logic [5:0]  mem_cs_n;
    logic [8:0]  mem_addr;
    logic        mem_adv_n, mem_oe_n, mem_we_n, mem_doe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dout;
    logic [15:0] mem_din;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_byte(req_byte), .rd_done(rd_done), .rd_data(rd_data),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_adv_n(mem_adv_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
    );

    int total = 0;
    int bad   = 0;

    // Shadow of the timing sets
    int sh_rec[NCS], sh_whold[NCS], sh_wd[NCS], sh_rd[NCS];
    int sh_wwait[NCS], sh_rwait[NCS], sh_ah[NCS], sh_a2o[NCS], sh_rhold[NCS];
    // Model of access history
    bit m_have = 0;
    bit m_read = 0;
    int m_cs   = 0;
    int m_page = 0;
    int m_rec  = 0;
    int g_ncs  = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic cfg_write(input int cs, input int field, input int val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_cs    = 3'(cs);
        cfg_field = 4'(field);
        cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we    = 1'b0;
        if (cs < NCS) begin
            case (field)
                0: sh_rec[cs]   = val & 15;
                1: sh_whold[cs] = val & 15;
                2: sh_wd[cs]    = val & 255;
                3: sh_rd[cs]    = val & 255;
                4: sh_wwait[cs] = val & 15;
                5: sh_rwait[cs] = val & 15;
                6: sh_ah[cs]    = val & 1;
                7: sh_a2o[cs]   = val & 3;
                8: sh_rhold[cs] = val & 15;
                default: ;
            endcase
        end
    endtask

    task automatic access(input int cs, input int addr, input bit wr, input bit byt,
                          input logic [15:0] wd, input logic [15:0] din);
        int rcy, dcy, ah, ld, exp_cs, exp_start, exp_nstr, exp_end;
        int pre, adv_c, n_adv, n_cs, n_oe, oe_c, n_we, we_c, n_doe;
        int bad_cs, bad_addr, bad_be, bad_dout, early_done, end_c;
        bit seen_cs, first, nrec, fin_done;
        logic [15:0] fin_data;
        logic [1:0] exp_be;

        first  = !(m_have && m_cs == cs && m_page == (addr >> 4));
        nrec   = m_have && m_read && (m_cs != cs || wr);
        rcy    = nrec ? imax(m_rec, 1) : 0;
        dcy    = first ? (wr ? sh_wd[cs] : sh_rd[cs]) : 0;
        ah     = sh_ah[cs];
        ld     = imax(sh_rhold[cs], sh_a2o[cs]);
        exp_be = byt ? ((addr & 1) ? 2'b01 : 2'b10) : 2'b00;
        if (wr) begin
            exp_nstr  = 1 + sh_wwait[cs];
            exp_cs    = 1 + ah + dcy + exp_nstr + sh_whold[cs] + 1;
            exp_start = rcy + 2 + ah + dcy;
        end else begin
            exp_nstr  = 1 + sh_rwait[cs];
            exp_cs    = 1 + ah + dcy + ld + exp_nstr;
            exp_start = rcy + 2 + ah + dcy + ld;
        end
        exp_end = rcy + exp_cs + 1;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_cs    = 3'(cs);
        req_addr  = 9'(addr);
        req_write = wr;
        req_byte  = byt;
        req_wdata = wd;
        mem_din   = din;
        @(posedge clk);
        #1 req_valid = 1'b0;

        pre = 0; adv_c = 0; n_adv = 0; n_cs = 0; n_oe = 0; oe_c = 0;
        n_we = 0; we_c = 0; n_doe = 0; bad_cs = 0; bad_addr = 0; bad_be = 0;
        bad_dout = 0; early_done = 0; end_c = 0; seen_cs = 0;
        fin_done = 0; fin_data = '0;
        for (int c = 1; c <= 3000; c++) begin
            @(negedge clk);
            if (req_ready) begin
                end_c    = c;
                fin_done = rd_done;
                fin_data = rd_data;
                break;
            end
            if (rd_done) early_done++;
            if (mem_cs_n != 6'h3f) begin
                seen_cs = 1;
                n_cs++;
                if (mem_cs_n != ~(6'b1 << cs)) bad_cs++;
                if (mem_addr != 9'(addr)) bad_addr++;
                if (mem_be_n != exp_be) bad_be++;
            end else if (!seen_cs) begin
                pre++;
            end
            if (!mem_adv_n) begin n_adv++; if (adv_c == 0) adv_c = c; end
            if (!mem_oe_n)  begin n_oe++;  if (oe_c == 0)  oe_c = c;  end
            if (!mem_we_n)  begin n_we++;  if (we_c == 0)  we_c = c;  end
            if (mem_doe) begin
                n_doe++;
                if (mem_dout != wd) bad_dout++;
                if (!mem_oe_n) bad_dout++;
            end
        end

        chk(pre == rcy, "R8 recovery cycles", pre, rcy);
        chk(adv_c == rcy + 1 && n_adv == 1, "R3 single ADV at start", adv_c, rcy + 1);
        chk(bad_cs == 0 && bad_addr == 0, "R3 chip select and address", bad_cs + bad_addr, 0);
        chk(n_cs == exp_cs, "R7 CS-low length with delta", n_cs, exp_cs);
        chk(bad_be == 0, "R11 byte lanes", bad_be, 0);
        chk(end_c == exp_end, "R10 ready return", end_c, exp_end);
        if (wr) begin
            chk(we_c == exp_start && n_we == exp_nstr, "R6 WE window", we_c, exp_start);
            chk(n_oe == 0 && n_doe == exp_nstr + sh_whold[cs] + 1 && bad_dout == 0,
                "R6 write drive and hold", n_doe, exp_nstr + sh_whold[cs] + 1);
            chk(!fin_done && early_done == 0, "R9 no done on write", int'(fin_done), 0);
        end else begin
            chk(oe_c == exp_start && n_oe == exp_nstr, "R5 OE window", oe_c, exp_start);
            chk(n_we == 0 && n_doe == 0, "R12 no drive on read", n_doe, 0);
            chk(fin_done && early_done == 0 && fin_data == din, "R9 read data",
                int'(fin_data), int'(din));
        end

        g_ncs  = n_cs;
        m_have = 1;
        m_cs   = cs;
        m_page = addr >> 4;
        m_read = !wr;
        if (!wr) m_rec = sh_rec[cs];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n1, n2;
        void'($urandom(32'd7151));
        for (int i = 0; i < NCS; i++) begin
            sh_rec[i] = 0; sh_whold[i] = 0; sh_wd[i] = 0; sh_rd[i] = 0;
            sh_wwait[i] = 0; sh_rwait[i] = 0; sh_ah[i] = 0; sh_a2o[i] = 0; sh_rhold[i] = 0;
        end
        rst_n = 1'b0; cfg_we = 0; cfg_cs = 0; cfg_field = 0; cfg_wdata = 0;
        req_valid = 0; req_cs = 0; req_addr = 0; req_wdata = 0; req_write = 0;
        req_byte = 0; mem_din = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(mem_cs_n == 6'h3f && mem_adv_n && mem_oe_n && mem_we_n,
            "R1 strobes idle", int'(mem_cs_n), 63);
        chk(!mem_doe && !rd_done && req_ready && mem_be_n == 2'b11,
            "R1 ready and drive", int'(req_ready), 1);

        // R2 loading, R5 read lead, R7 delta, R8 clamp
        cfg_write(0, 0, 0);
        cfg_write(0, 3, 5);
        cfg_write(0, 5, 2);
        cfg_write(0, 8, 3);
        cfg_write(0, 7, 1);
        access(0, 9'h010, 0, 0, 16'h0, 16'hA5C3);
        access(0, 9'h015, 0, 0, 16'h0, 16'h1234);
        access(0, 9'h016, 1, 0, 16'hBEEF, 16'h0);
        cfg_write(1, 0, 3);
        access(1, 9'h016, 0, 0, 16'h0, 16'h5A5A);
        cfg_write(2, 2, 7);
        cfg_write(2, 4, 3);
        cfg_write(2, 1, 2);
        access(2, 9'h0A1, 1, 1, 16'hC0DE, 16'h0);
        access(2, 9'h0A2, 1, 1, 16'h00FF, 16'h0);

        // R4 address hold adds one cycle
        access(3, 9'h040, 0, 0, 16'h0, 16'h7777);
        access(3, 9'h041, 0, 0, 16'h0, 16'h7778);
        n1 = g_ncs;
        cfg_write(3, 6, 1);
        access(3, 9'h042, 0, 0, 16'h0, 16'h7779);
        n2 = g_ncs;
        chk(n2 == n1 + 1, "R4 address hold cycle", n2, n1 + 1);

        // R2 out-of-range writes leave timing unchanged
        cfg_write(6, 5, 15);
        cfg_write(7, 3, 200);
        cfg_write(3, 9, 255);
        cfg_write(3, 15, 255);
        access(3, 9'h043, 0, 0, 16'h0, 16'h777A);
        chk(g_ncs == n2, "R2 ignored field writes", g_ncs, n2);

        // Random mix
        for (int k = 0; k < 90; k++) begin
            int cs, addr;
            if ($urandom_range(3) == 0)
                cfg_write(int'($urandom_range(7)), int'($urandom_range(10)),
                          int'($urandom_range(255)));
            cs   = ($urandom_range(2) == 0) ? m_cs : int'($urandom_range(5));
            addr = ($urandom_range(1) == 0) ? ((m_page << 4) | int'($urandom_range(15)))
                                            : int'($urandom_range(511));
            access(cs, addr, 1'($urandom_range(1)), 1'($urandom_range(1)),
                   16'($urandom), 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule